// File: doc/BRIEF.md
# Data-Ready Triggered Frame Select Generator

This block is host-side glue for a processor whose SPI port can run a DMA transfer but cannot drive a separate select line toward a converter. It watches the converter's active-low data-ready output and produces an active-low select window whose length is counted in host serial clock (SCLK) cycles. Each result can then be read without software toggling a pin. The SPI master itself is outside the block. SCLK is assumed to run continuously, because it is the only clock the block has.

After reset the block first runs a short configuration phase. Select is held high for a few cycles and then pulled low for a fixed number of frames. During these frames the block drives the register-write command bits on its own serial output, MSB first, with leading zero padding up to the frame length. When the last configuration frame ends, the block switches to readout. From then on, each falling edge of data-ready opens exactly one frame.

The frame length is 24 or 32 clocks and is chosen by an input. The host switches to 32 once the converter's status word has been enabled. A data-ready edge that arrives while a frame is still open is dropped and recorded in a sticky overrun flag.

Top module: `frame_select_gen`

## Requirements
- R1: While reset is held and right after it, cs_n is 1 and busy, cfg_mosi, readout and overrun are 0.
- R2: The first configuration frame opens (cs_n low) on the CFG_GAP-th rising SCLK edge after reset release. Later configuration frames each follow exactly CFG_GAP high cycles after the previous one closes. CFG_FRAMES frames are sent, word 0 (bits CMD_W-1:0 of CFG_WORDS) first.
- R3: In cycle c (0 = first low cycle) of a configuration frame of length L, cfg_mosi equals bit L-1-c of the command word zero-extended to L bits, so the padding zeros come first and the command follows MSB first. cfg_mosi is 0 whenever cs_n is 1 and in every readout frame.
- R4: len_sel=0 selects 24 cycles and len_sel=1 selects 32. cs_n stays low for exactly that many cycles and returns high on the rising edge that completes the count. The length is taken at the edge the frame opens, and later changes of len_sel do not alter that frame.
- R5: readout rises on the edge that closes the last configuration frame and then stays 1. Data-ready activity before that opens no frame and does not set overrun.
- R6: In readout, a high-to-low change of drdy_n opens a frame on the third rising edge counting the first edge that samples it low. A level held low opens only one frame.
- R7: A data-ready falling edge whose trigger cycle finds busy high opens no frame and sets overrun. overrun stays 1 until reset.
- R8: busy is 1 exactly in the cycles where cs_n is 0.
- R9: A data-ready falling edge whose trigger cycle is the first cycle after a frame closes opens a new frame at once, leaving cs_n high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Host serial clock, free-running; all logic on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous to sclk |
| len_sel | input | 1 | Frame length select: 0 = 24 clocks, 1 = 32 clocks |
| cs_n | output | 1 | Generated active-low select toward the converter |
| busy | output | 1 | High while a frame window is open |
| cfg_mosi | output | 1 | Serial command bit during configuration frames, else 0 |
| readout | output | 1 | High once the configuration phase has finished |
| overrun | output | 1 | Sticky flag: a data-ready edge arrived during a frame |

## Verification
The bench builds the block with two configuration words (0x8880 first, 0xA5C3 second) and a three-cycle gap. This puts word ordering, the inter-frame gap count and the zero padding of both words within reach for each frame length. A full configuration phase is swept cycle by cycle under both len_sel values while data-ready toggles, checking that the toggling is ignored. In readout, a second data-ready edge is swept across every offset from the middle of a frame to just past its end, for both lengths. This reaches the overrun point, the last cycle of a frame and back-to-back frames. Flipping len_sel every cycle inside a frame shows that the length is fixed when the frame opens.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [1:0] {
    SEQ_GAP   = 2'd0,
    SEQ_FRAME = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  // Frame length in SCLK cycles for a given select value.
  function automatic int unsigned fsg_frame_len(input logic sel,
                                                input int unsigned short_len,
                                                input int unsigned long_len);
    return sel ? long_len : short_len;
  endfunction

  // Bit sent in cycle pos of a frame of length len carrying a command
  // right-aligned in the frame (leading zero padding, MSB first).
  function automatic logic fsg_pad_bit(input logic [63:0] cmd,
                                       input int unsigned len,
                                       input int unsigned pos);
    int unsigned bitpos;
    if (pos >= len) return 1'b0;
    bitpos = len - 1 - pos;
    if (bitpos > 63) return 1'b0;
    return cmd[bitpos[5:0]];
  endfunction

endpackage

// File: rtl/fsg_drdy_sync.sv
module fsg_drdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic drdy_fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Synchronizer chain plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], drdy_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign drdy_fall = prev_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_fall |=> !drdy_fall); // R6

endmodule

// File: rtl/fsg_frame_engine.sv
module fsg_frame_engine import fsg_pkg::*; #(
  parameter int unsigned SHORT_LEN = 24,
  parameter int unsigned LONG_LEN  = 32,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             len_sel,
  output logic             active,
  output logic             cs_n,
  output logic [CNT_W-1:0] bit_idx,
  output logic [CNT_W-1:0] frame_len,
  output logic             last,
  output logic             accept,
  output logic             reject
);

  logic             active_q;
  logic             cs_n_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  assign last   = active_q && (cnt_q == len_q - CNT_W'(1));
  assign accept = start && !active_q;
  assign reject = start && active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cs_n_q   <= 1'b1;
      cnt_q    <= '0;
      len_q    <= CNT_W'(SHORT_LEN);
    end else if (accept) begin
      active_q <= 1'b1;
      cs_n_q   <= 1'b0;
      cnt_q    <= '0;
      len_q    <= CNT_W'(fsg_frame_len(len_sel, SHORT_LEN, LONG_LEN));
    end else if (active_q) begin
      if (last) begin
        active_q <= 1'b0;
        cs_n_q   <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active    = active_q;
  assign cs_n      = cs_n_q;
  assign bit_idx   = cnt_q;
  assign frame_len = len_q;

  // Independent tally of low cycles, used only by the width check.
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_run_q <= '0;
    else if (!cs_n_q) low_run_q <= low_run_q + (CNT_W+1)'(1);
    else           low_run_q <= '0;
  end

  AST_CS_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    active_q == !cs_n_q); // R8
  AST_FRAME_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> low_run_q == {1'b0, len_q}); // R4
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last) |=> $stable(len_q)); // R4

endmodule

// File: rtl/fsg_cfg_seq.sv
module fsg_cfg_seq import fsg_pkg::*; #(
  parameter int unsigned CFG_FRAMES = 1,
  parameter int unsigned CMD_W      = 16,
  parameter int unsigned CFG_GAP    = 2,
  parameter int unsigned CNT_W      = 6,
  parameter logic [CFG_FRAMES*CMD_W-1:0] CFG_WORDS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_active,
  input  logic             frame_last,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic [CNT_W-1:0] frame_len,
  output logic             cfg_start,
  output logic             cfg_mosi,
  output logic             readout
);

  localparam int unsigned GAP_W = (CFG_GAP > 1) ? $clog2(CFG_GAP) : 1;
  localparam int unsigned IDX_W = (CFG_FRAMES > 1) ? $clog2(CFG_FRAMES) : 1;

  seq_state_e       state_q;
  logic [GAP_W-1:0] gap_q;
  logic [IDX_W-1:0] idx_q;
  logic [CMD_W-1:0] word;
  logic             gap_done;
  logic             last_cfg;

  assign gap_done  = (gap_q == GAP_W'(CFG_GAP - 1));
  assign last_cfg  = (idx_q == IDX_W'(CFG_FRAMES - 1));
  assign cfg_start = (state_q == SEQ_GAP) && gap_done;
  assign readout   = (state_q == SEQ_RUN);
  assign word      = CFG_WORDS[int'(idx_q)*CMD_W +: CMD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_GAP;
      gap_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SEQ_GAP: begin
          if (gap_done) begin
            state_q <= SEQ_FRAME;
            gap_q   <= '0;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        SEQ_FRAME: begin
          if (frame_last) begin
            if (last_cfg) begin
              state_q <= SEQ_RUN;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= SEQ_GAP;
            end
          end
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign cfg_mosi = (state_q == SEQ_FRAME) && frame_active &&
                    fsg_pad_bit(64'(word), 32'(frame_len), 32'(bit_idx));

  AST_READOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    readout |=> readout); // R5
  AST_CFG_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_FRAME) |-> frame_active); // R2

endmodule

// File: rtl/frame_select_gen.sv
module frame_select_gen import fsg_pkg::*; #(
  parameter int unsigned SHORT_LEN   = 24,
  parameter int unsigned LONG_LEN    = 32,
  parameter int unsigned CMD_W       = 16,
  parameter int unsigned CFG_FRAMES  = 1,
  parameter logic [CFG_FRAMES*CMD_W-1:0] CFG_WORDS = 16'h8880,
  parameter int unsigned CFG_GAP     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic drdy_n,
  input  logic len_sel,
  output logic cs_n,
  output logic busy,
  output logic cfg_mosi,
  output logic readout,
  output logic overrun
);

  localparam int unsigned CNT_W = $clog2(LONG_LEN + 1);

  logic             drdy_fall;
  logic             cfg_start;
  logic             start;
  logic             active;
  logic             last;
  logic             accept;
  logic             reject;
  logic [CNT_W-1:0] bit_idx;
  logic [CNT_W-1:0] frame_len;
  logic             ovr_q;

  fsg_drdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (sclk),
    .rst_n     (rst_n),
    .drdy_n    (drdy_n),
    .drdy_fall (drdy_fall)
  );

  // The sequencer owns the select until readout; data-ready owns it after.
  assign start = readout ? drdy_fall : cfg_start;

  fsg_frame_engine #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .CNT_W     (CNT_W)
  ) u_engine (
    .clk       (sclk),
    .rst_n     (rst_n),
    .start     (start),
    .len_sel   (len_sel),
    .active    (active),
    .cs_n      (cs_n),
    .bit_idx   (bit_idx),
    .frame_len (frame_len),
    .last      (last),
    .accept    (accept),
    .reject    (reject)
  );

  fsg_cfg_seq #(
    .CFG_FRAMES (CFG_FRAMES),
    .CMD_W      (CMD_W),
    .CFG_GAP    (CFG_GAP),
    .CNT_W      (CNT_W),
    .CFG_WORDS  (CFG_WORDS)
  ) u_seq (
    .clk          (sclk),
    .rst_n        (rst_n),
    .frame_active (active),
    .frame_last   (last),
    .bit_idx      (bit_idx),
    .frame_len    (frame_len),
    .cfg_start    (cfg_start),
    .cfg_mosi     (cfg_mosi),
    .readout      (readout)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                ovr_q <= 1'b0;
    else if (readout && reject) ovr_q <= 1'b1;
  end

  assign busy    = active;
  assign overrun = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge sclk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_OVR_CAUSE: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(overrun) |-> $past(busy)); // R7
  AST_CFG_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    !readout |-> !overrun); // R5
  AST_MOSI_IDLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (cs_n || readout) |-> !cfg_mosi); // R3

endmodule

// File: tb/tb_frame_select_gen.sv
`timescale 1ns/1ps
module tb_frame_select_gen;

  localparam int SL   = 24;
  localparam int LL   = 32;
  localparam int GAP  = 3;
  localparam int NCF  = 2;
  localparam logic [31:0] WORDS = 32'hA5C3_8880;

  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy_n = 1'b1;
  logic len_sel = 1'b0;
  logic cs_n, busy, cfg_mosi, readout, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state for readout, built from R4, R6, R7, R9.
  logic [3:0] hist;
  bit m_busy, m_ovr;
  int m_cnt, m_len;

  frame_select_gen #(
    .CFG_FRAMES (NCF),
    .CFG_WORDS  (WORDS),
    .CFG_GAP    (GAP)
  ) dut (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .drdy_n   (drdy_n),
    .len_sel  (len_sel),
    .cs_n     (cs_n),
    .busy     (busy),
    .cfg_mosi (cfg_mosi),
    .readout  (readout),
    .overrun  (overrun)
  );

  always #2.5 sclk = ~sclk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    hist = 4'hF; m_busy = 0; m_ovr = 0; m_cnt = 0; m_len = SL;
  endtask

  // Drive inputs for the next edge, advance the model, sample after the edge.
  task automatic step(input logic v, input logic ls);
    bit fall;
    drdy_n = v;
    len_sel = ls;
    hist = {hist[2:0], v};
    fall = hist[3] && !hist[2];
    if (m_busy) begin
      if (fall) m_ovr = 1;
      if (m_cnt == m_len - 1) m_busy = 0;
      else m_cnt++;
    end else if (fall) begin
      m_busy = 1; m_cnt = 0; m_len = ls ? LL : SL;
    end
    @(negedge sclk);
    check("R6 R9 cs_n", {31'd0, cs_n}, {31'd0, !m_busy});
    check("R8 busy", {31'd0, busy}, {31'd0, m_busy});
    check("R7 overrun", {31'd0, overrun}, {31'd0, m_ovr});
    check("R3 mosi in readout", {31'd0, cfg_mosi}, 32'd0);
  endtask

  task automatic do_reset(input logic ls);
    rst_n = 0; drdy_n = 1; len_sel = ls;
    repeat (3) @(negedge sclk);
    check("R1 cs_n", {31'd0, cs_n}, 32'd1);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 mosi", {31'd0, cfg_mosi}, 32'd0);
    check("R1 readout", {31'd0, readout}, 32'd0);
    check("R1 overrun", {31'd0, overrun}, 32'd0);
    rst_n = 1;
  endtask

  // Whole configuration phase, cycle by cycle, with data-ready toggling.
  task automatic config_sweep(input logic ls);
    int L, total, ro_at;
    L = ls ? LL : SL;
    ro_at = GAP + (NCF - 1) * (L + GAP) + L;
    total = ro_at + 3;
    for (int n = 1; n <= total; n++) begin
      bit exp_low, exp_bit;
      drdy_n = (n < total - 8) ? ((n % 5) >= 2) : 1'b1;
      len_sel = ls;
      @(negedge sclk);
      exp_low = 0; exp_bit = 0;
      for (int f = 0; f < NCF; f++) begin
        int s;
        s = GAP + f * (L + GAP);
        if (n >= s && n < s + L) begin
          int pos;
          logic [15:0] w;
          w = WORDS[f*16 +: 16];
          pos = L - 1 - (n - s);
          exp_low = 1;
          exp_bit = (pos < 16) ? w[pos] : 1'b0;
        end
      end
      check("R2 cfg cs_n", {31'd0, cs_n}, {31'd0, !exp_low});
      check("R8 cfg busy", {31'd0, busy}, {31'd0, exp_low});
      check("R3 cfg mosi", {31'd0, cfg_mosi}, {31'd0, exp_bit});
      check("R5 readout", {31'd0, readout}, {31'd0, (n >= ro_at)});
      check("R5 overrun quiet", {31'd0, overrun}, 32'd0);
    end
    model_clear();
  endtask

  // One triggered frame; flip toggles len_sel every cycle after the start edge.
  task automatic trig_frame(input logic ls, input bit flip);
    int lows;
    lows = 0;
    step(0, ls); if (!cs_n) lows++;
    step(1, ls); if (!cs_n) lows++;
    step(1, ls); if (!cs_n) lows++;
    for (int k = 0; k < LL + 6; k++) begin
      step(1, flip ? (ls ^ logic'(k % 2 == 0)) : ls);
      if (!cs_n) lows++;
    end
    check("R4 low cycles", lows, ls ? LL : SL);
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset(0);
    config_sweep(0);
    repeat (4) step(1, 0);
    trig_frame(0, 0);
    trig_frame(1, 0);
    trig_frame(0, 1); // R4 mid-frame length changes
    trig_frame(1, 1);

    // R6: level held low opens only one frame
    begin
      int lows;
      lows = 0;
      for (int k = 0; k < 80; k++) begin
        step(0, 0);
        if (!cs_n) lows++;
      end
      check("R6 held low single frame", lows, SL);
      repeat (4) step(1, 0);
    end

    check("R7 no overrun yet", {31'd0, overrun}, 32'd0);

    // R7 R9: second edge swept across a frame and just past its end
    for (int ls = 0; ls < 2; ls++) begin
      int L;
      L = ls ? LL : SL;
      for (int off = 0; off <= L + 3; off++) begin
        step(0, logic'(ls));
        for (int k = 0; k <= off; k++) step(1, logic'(ls));
        step(0, logic'(ls));
        for (int k = 0; k < L + 8; k++) step(1, logic'(ls));
      end
    end
    check("R7 overrun sticky", {31'd0, overrun}, 32'd1);

    // R1 R7: reset clears overrun; repeat configuration with long frames
    do_reset(1);
    config_sweep(1);
    repeat (4) step(1, 1);
    trig_frame(1, 0);
    trig_frame(0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule